// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block is the slave-side command front end of a serial NOR flash. It oversamples the SPI pins with the chip clock, which is assumed to be several times faster than the serial clock. It shifts in an 8-bit command and, where the command has one, a 24-bit address, both most significant bit first. It answers the three array-read commands from a simple byte port, and it owns the write-enable latch and the output-enable of the serial output line. The latch, the reads and the hold pin all have their own rules. Commands that act on chip-select release are committed only when the release falls after a whole number of bytes. A release made while hold is asserted aborts whatever was in flight and clears the latch.

The array itself lives elsewhere. Read data comes from a combinational byte port addressed by `rd_addr`. Program and erase commands are not carried out here: they are passed on to a downstream sequencer as a one-cycle request that carries the command and the address. The data bytes of a page program are streamed out as they arrive.

Top module: `spi_flash_front`

## Requirements
- R1: SPI mode 0 (clock idling low) and mode 3 (clock idling high) are both accepted and give identical results; input is sampled on rising serial-clock edges and output changes only on falling edges.
- R2: After chip-select falls, the first 8 bits form the command and the next 24 bits form the address, each most significant bit first; address bits at and above position AW are discarded.
- R3: Command 03h returns data starting with the first falling clock edge after the last address bit, each byte MSB first, from consecutive addresses starting at the given one.
- R4: Command 0Bh inserts one dummy byte and command 1Bh inserts two dummy bytes between the address and the first data bit.
- R5: A sequential read that passes address 2^AW-1 continues at address 0.
- R6: Raising chip-select during a read, even mid-byte, removes the output enable within a few chip-clock cycles.
- R7: Command 06h sets the write-enable latch and 04h clears it, only when chip-select rises after a multiple of 8 clocks; otherwise the latch keeps its value.
- R8: While the hold input is low, serial-clock edges are ignored and the output enable is low; the transfer resumes where it stopped once hold is released.
- R9: If chip-select rises while hold is low, the write-enable latch is cleared and no request is issued.
- R10: Erase commands 20h, 52h and D8h with exactly 4 bytes, chip erase 60h or C7h with exactly 1 byte, and program 02h with at least 5 bytes issue a one-cycle `cmd_go` with `cmd_op` and `cmd_addr` only when the latch is set and chip-select rises on a byte boundary; the latch is then cleared. Otherwise no request is issued and the latch keeps its value.
- R11: For command 02h, each complete byte after the address appears on `wr_data` with a one-cycle `wr_valid` pulse.
- R12: After reset the output enable is low, the write-enable latch is 0 and no request or data pulse is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Hold, active low |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the serial data out pad |
| rd_addr | output | AW | Byte address presented to the array read port |
| rd_data | input | 8 | Byte returned by the array read port for `rd_addr` |
| wr_en_latch | output | 1 | Current write-enable latch |
| cmd_go | output | 1 | One-cycle program or erase request |
| cmd_op | output | 8 | Command code of the request |
| cmd_addr | output | AW | Address of the request |
| wr_valid | output | 1 | One-cycle strobe for a program data byte |
| wr_data | output | 8 | Program data byte |

## Verification
The hardest case to reach from the ports is a hold that lands inside a read after a data byte has already been loaded for output. The resumed bits must continue from the held byte, without slipping or repeating an address. The stimulus drops hold right after the falling edge that loads the next byte, toggles the serial clock while hold is low, and then finishes the byte. A second delicate case is a chip-select release while hold is still low. For this the bench sends a complete, otherwise valid write-enable and holds hold low across the release, so only the hold rule can explain a cleared latch.

// File: rtl/spi_flash_front.sv
module spi_flash_front #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sck,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  input  logic          spi_hold_n,
  output logic          spi_miso,
  output logic          spi_miso_oe,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data,
  output logic          wr_en_latch,
  output logic          cmd_go,
  output logic [7:0]    cmd_op,
  output logic [AW-1:0] cmd_addr,
  output logic          wr_valid,
  output logic [7:0]    wr_data
);

  localparam logic [5:0] CNT_MAX = 6'd63;

  logic [1:0] sck_m, cs_m, mosi_m, hold_m;
  logic sck_d, cs_d;
  logic sck_s, cs_s, mosi_s, hold_s;

  assign sck_s  = sck_m[1];
  assign cs_s   = cs_m[1];
  assign mosi_s = mosi_m[1];
  assign hold_s = hold_m[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_m  <= 2'b00;
      cs_m   <= 2'b11;
      mosi_m <= 2'b00;
      hold_m <= 2'b11;
      sck_d  <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sck_m  <= {sck_m[0], spi_sck};
      cs_m   <= {cs_m[0], spi_cs_n};
      mosi_m <= {mosi_m[0], spi_mosi};
      hold_m <= {hold_m[0], spi_hold_n};
      sck_d  <= sck_s;
      cs_d   <= cs_s;
    end
  end

  logic cs_fall, cs_rise, live, sck_up, sck_dn;
  assign cs_fall = cs_d & ~cs_s;
  assign cs_rise = ~cs_d & cs_s;
  assign live    = ~cs_s & hold_s;
  assign sck_up  = live & sck_s & ~sck_d;
  assign sck_dn  = live & ~sck_s & sck_d;

  logic [5:0]    bcnt;
  logic [2:0]    nbit, obit;
  logic [7:0]    sh, op, osh;
  logic [AW-1:0] addr;
  logic          drv, miso_r, wel;

  logic [5:0] hdr;
  logic       is_rd;
  always_comb begin
    is_rd = 1'b1;
    hdr   = CNT_MAX;
    case (op)
      8'h03:   hdr = 6'd32;
      8'h0B:   hdr = 6'd40;
      8'h1B:   hdr = 6'd48;
      default: is_rd = 1'b0;
    endcase
  end

  logic dph, aligned, len_ok;
  assign dph     = is_rd & (bcnt >= hdr);
  assign aligned = (nbit == 3'd0) & (bcnt >= 6'd8);

  always_comb begin
    case (op)
      8'h02:               len_ok = bcnt >= 6'd40;
      8'h20, 8'h52, 8'hD8: len_ok = bcnt == 6'd32;
      8'h60, 8'hC7:        len_ok = bcnt == 6'd8;
      default:             len_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt     <= '0;
      nbit     <= '0;
      obit     <= '0;
      sh       <= '0;
      op       <= '0;
      osh      <= '0;
      addr     <= '0;
      drv      <= 1'b0;
      miso_r   <= 1'b0;
      wel      <= 1'b0;
      cmd_go   <= 1'b0;
      cmd_op   <= '0;
      cmd_addr <= '0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
    end else begin
      cmd_go   <= 1'b0;
      wr_valid <= 1'b0;
      if (cs_fall) begin
        bcnt <= '0;
        nbit <= '0;
        obit <= '0;
        op   <= '0;
        drv  <= 1'b0;
      end else if (cs_rise) begin
        drv <= 1'b0;
        if (!hold_s) begin
          wel <= 1'b0;
        end else if (aligned) begin
          if (op == 8'h06) wel <= 1'b1;
          else if (op == 8'h04) wel <= 1'b0;
          else if (len_ok && wel) begin
            cmd_go   <= 1'b1;
            cmd_op   <= op;
            cmd_addr <= addr;
            wel      <= 1'b0;
          end
        end
      end else if (sck_up) begin
        sh   <= {sh[6:0], mosi_s};
        nbit <= nbit + 3'd1;
        if (bcnt != CNT_MAX) bcnt <= bcnt + 6'd1;
        if (bcnt == 6'd7) op <= {sh[6:0], mosi_s};
        else if (bcnt >= 6'd8 && bcnt < 6'd32) addr <= {addr[AW-2:0], mosi_s};
        if (op == 8'h02 && bcnt >= 6'd39 && nbit == 3'd7) begin
          wr_valid <= 1'b1;
          wr_data  <= {sh[6:0], mosi_s};
        end
      end else if (sck_dn && dph) begin
        obit <= obit + 3'd1;
        drv  <= 1'b1;
        if (obit == 3'd0) begin
          osh    <= rd_data;
          miso_r <= rd_data[7];
          addr   <= addr + 1'b1;
        end else begin
          miso_r <= osh[3'd7 - obit];
        end
      end
    end
  end

  assign rd_addr     = addr;
  assign spi_miso    = miso_r;
  assign spi_miso_oe = drv & live;
  assign wr_en_latch = wel;

  // R6
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !spi_miso_oe);

  // R7
  wel_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wel) |-> $past(cs_rise));

  // R10
  go_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> (!wel && $past(wel)));

  // R8
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_s && !cs_s && !cs_d) |=> ($stable(bcnt) && $stable(nbit)));

  // R3
  oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_miso_oe |-> is_rd);

  // R11
  wr_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (op == 8'h02));

endmodule

// File: tb/spi_flash_front_test.sv
module spi_flash_front_test;
  localparam int AW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, hold_n = 1'b1;
  logic miso, miso_oe, wel, cmd_go, wr_valid;
  logic [AW-1:0] rd_addr, cmd_addr;
  logic [7:0] rd_data, cmd_op, wr_data;

  always #2 clk = ~clk;

  function automatic logic [7:0] pat(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h3C;
  endfunction
  assign rd_data = pat(rd_addr);

  spi_flash_front #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_hold_n(hold_n), .spi_miso(miso), .spi_miso_oe(miso_oe),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_en_latch(wel),
    .cmd_go(cmd_go), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .wr_valid(wr_valid), .wr_data(wr_data));

  int checks = 0, errors = 0, go_cnt = 0, wr_cnt = 0;
  logic [7:0] last_op;
  logic [AW-1:0] last_addr;
  logic [7:0] wr_log [16];
  logic m3 = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (cmd_go) begin go_cnt++; last_op = cmd_op; last_addr = cmd_addr; end
    if (wr_valid) begin wr_log[wr_cnt % 16] = wr_data; wr_cnt++; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic half(); repeat (8) @(negedge clk); endtask
  task automatic sel(input logic mode3);
    m3 = mode3; sck = mode3; half(); cs_n = 1'b0; half();
  endtask
  task automatic desel();
    if (!m3) sck = 1'b0;
    half(); cs_n = 1'b1; half();
  endtask
  task automatic bit_x(input logic b, output logic r);
    sck = 1'b0; mosi = b; half(); r = miso; sck = 1'b1; half();
  endtask
  task automatic byte_x(input logic [7:0] b, output logic [7:0] r);
    logic t;
    for (int i = 7; i >= 0; i--) begin bit_x(b[i], t); r[i] = t; end
  endtask
  task automatic sendb(input logic [7:0] b);
    logic [7:0] d;
    byte_x(b, d);
  endtask
  task automatic cmd1(input logic mode3, input logic [7:0] opc);
    sel(mode3); sendb(opc); desel();
  endtask
  task automatic cmd4(input logic [7:0] opc, input logic [23:0] a);
    sel(1'b0); sendb(opc); sendb(a[23:16]); sendb(a[15:8]); sendb(a[7:0]); desel();
  endtask

  // {mode3, opcode, address}: R1 mode mix, R3 03h, R4 0Bh/1Bh, R5 wrap and upper bits
  localparam logic [32:0] VEC [7] = '{
    {1'b0, 8'h03, 24'h000010},
    {1'b1, 8'h03, 24'h012345},
    {1'b0, 8'h0B, 24'h0ABCDE},
    {1'b1, 8'h0B, 24'h00FFFE},
    {1'b0, 8'h1B, 24'h055555},
    {1'b1, 8'h1B, 24'hF0F0F0},
    {1'b0, 8'h03, 24'hFFFFFF}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    finish_up();
  end

  initial begin
    logic [7:0] rb;
    logic [19:0] a;
    logic t;
    int g0, w0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    half();
    // R12 reset state
    chk("R12 oe", miso_oe, 0);
    chk("R12 latch", wel, 0);
    chk("R12 requests", go_cnt + wr_cnt, 0);

    // R1 R2 R3 R4 R5 read vectors
    for (int v = 0; v < 7; v++) begin
      logic [32:0] e;
      int nd;
      e = VEC[v];
      nd = (e[31:24] == 8'h03) ? 0 : (e[31:24] == 8'h0B) ? 1 : 2;
      sel(e[32]);
      sendb(e[31:24]); sendb(e[23:16]); sendb(e[15:8]); sendb(e[7:0]);
      for (int k = 0; k < nd; k++) sendb(8'h00);
      for (int k = 0; k < 3; k++) begin
        byte_x(8'h00, rb);
        a = e[19:0] + 20'(k);
        chk(nd == 0 ? "R3 R1 R5 read byte" : "R4 R1 R5 read byte", rb, pat(a));
      end
      chk("R3 oe during data", miso_oe, 1);
      desel();
      chk("R6 oe after release", miso_oe, 0);
    end

    // R6 release mid-byte
    sel(1'b0);
    sendb(8'h03); sendb(8'h00); sendb(8'h02); sendb(8'h00);
    for (int i = 0; i < 4; i++) bit_x(1'b0, t);
    chk("R6 oe mid-byte", miso_oe, 1);
    cs_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R6 oe dropped", miso_oe, 0);
    sck = 1'b0; half();

    // R7 write-enable latch
    cmd1(1'b0, 8'h06); chk("R7 set", wel, 1);
    cmd1(1'b1, 8'h04); chk("R7 R1 clear mode3", wel, 0);
    sel(1'b0); sendb(8'h06); bit_x(1'b0, t); desel();
    chk("R7 9 bits ignored", wel, 0);
    cmd1(1'b1, 8'h06); chk("R7 R1 set mode3", wel, 1);
    sel(1'b0); for (int i = 0; i < 7; i++) bit_x(1'b0, t); desel();
    chk("R7 7 bits ignored", wel, 1);

    // R9 release under hold
    g0 = go_cnt;
    sel(1'b0); sendb(8'h06);
    sck = 1'b0; half(); hold_n = 1'b0; half(); cs_n = 1'b1; half(); hold_n = 1'b1; half();
    chk("R9 latch cleared", wel, 0);
    chk("R9 no request", go_cnt, g0);

    // R8 hold during opcode and during data
    sel(1'b0);
    for (int i = 7; i >= 4; i--) bit_x(1'b0, t);
    sck = 1'b0; half(); hold_n = 1'b0; half();
    for (int i = 0; i < 3; i++) begin sck = 1'b1; mosi = 1'b1; half(); sck = 1'b0; half(); end
    hold_n = 1'b1; half();
    bit_x(1'b0, t); bit_x(1'b0, t); bit_x(1'b1, t); bit_x(1'b1, t);
    sendb(8'h00); sendb(8'h04); sendb(8'h20);
    byte_x(8'h00, rb);
    chk("R8 byte after opcode hold", rb, pat(20'h00420));
    sck = 1'b0; half(); hold_n = 1'b0; half();
    chk("R8 oe low in hold", miso_oe, 0);
    for (int i = 0; i < 2; i++) begin sck = 1'b1; half(); sck = 1'b0; half(); end
    hold_n = 1'b1; half();
    byte_x(8'h00, rb);
    chk("R8 byte after data hold", rb, pat(20'h00421));
    desel();

    // R10 erase requests
    cmd1(1'b0, 8'h06);
    g0 = go_cnt;
    cmd4(8'h20, 24'h123456);
    chk("R10 go issued", go_cnt, g0 + 1);
    chk("R10 op", last_op, 8'h20);
    chk("R10 R2 addr masked", last_addr, 20'h23456);
    chk("R10 latch cleared", wel, 0);
    cmd4(8'h20, 24'h000000);
    chk("R10 no go without latch", go_cnt, g0 + 1);
    cmd1(1'b0, 8'h06);
    sel(1'b0); sendb(8'hD8); sendb(8'h01); sendb(8'h00); sendb(8'h00); sendb(8'h00); desel();
    chk("R10 wrong length no go", go_cnt, g0 + 1);
    chk("R10 wrong length keeps latch", wel, 1);
    cmd1(1'b1, 8'hC7);
    chk("R10 chip erase go", go_cnt, g0 + 2);
    chk("R10 chip erase op", last_op, 8'hC7);

    // R11 program data
    cmd1(1'b0, 8'h06);
    w0 = wr_cnt;
    sel(1'b0); sendb(8'h02); sendb(8'h00); sendb(8'h01); sendb(8'h00);
    sendb(8'hAA); sendb(8'h55); desel();
    chk("R11 byte count", wr_cnt, w0 + 2);
    chk("R11 byte 0", wr_log[w0 % 16], 8'hAA);
    chk("R11 byte 1", wr_log[(w0 + 1) % 16], 8'h55);
    chk("R10 program op", last_op, 8'h02);
    chk("R10 program addr", last_addr, 20'h00100);
    chk("R10 program clears latch", wel, 0);

    finish_up();
  end
endmodule